// File: doc/BRIEF.md
# Write Strobe Lane Window Monitor

This block watches the write address and write data channels of an AXI interface. It follows one write burst at a time. On the address handshake it records the start address, transfer size, beat count and burst type. For each data beat it then works out which byte lanes of the data bus the beat may use. The window is 2^size bytes wide. It starts at the lane given by the start address and moves according to the burst type: it stays in place for FIXED bursts, steps upward for INCR bursts and wraps at the burst boundary for WRAP bursts.

Within that window any strobe value is legal, including all zeros, and the value may change from beat to beat. The monitor flags a strobe bit that falls outside the window. It also flags a last-beat marker that is placed wrongly. The current window is driven out as a lane mask, so a scoreboard or a waveform viewer can show it. Each error output is a one-cycle pulse.

Top module: `wstrb_lane_monitor`

## Requirements
- R1: After reset the lane mask is zero and both error outputs are low. Bit i of `lane_mask` stands for byte lane i, which is data bits [8i+7:8i].
- R2: On the first beat of a burst the mask covers the lanes from (address mod bus bytes) up to, but not including, the next 2^size boundary. An aligned address therefore gives exactly 2^size lanes.
- R3: Burst encoding is 0 = FIXED, 1 = INCR, 2 = WRAP. In a FIXED burst the mask is the same on every beat.
- R4: In an INCR burst every beat after the first uses the aligned window one transfer size above the previous beat's aligned address. The lane offset is taken modulo the bus width, so the window returns to lane 0 after the top lane.
- R5: In a WRAP burst the beat address advances by 2^size and wraps within an aligned block of (len+1)·2^size bytes. The mask follows that address.
- R6: A beat whose strobe is a subset of the mask, including zero, raises no `strb_err`.
- R7: A beat with any strobe bit outside the mask raises `strb_err` for exactly the one cycle after that beat's handshake.
- R8: A burst has len+1 beats. `last_err` pulses for one cycle after a beat handshake when `w_last` is low on the final beat or high on any earlier beat.
- R9: After the final beat the monitor is idle. The mask is zero, and data beats that arrive while idle raise no error.
- R10: An address handshake is captured only while idle. One that arrives during a burst leaves the windows of the current burst unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_addr | input | ADDR_W | Burst start address |
| aw_size | input | 3 | log2 of bytes per transfer |
| aw_len | input | 8 | Beats minus one |
| aw_burst | input | 2 | Burst type (0 FIXED, 1 INCR, 2 WRAP) |
| w_valid | input | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_strb | input | DATA_W/8 | Byte strobes of the beat |
| w_last | input | 1 | Final-beat marker |
| lane_mask | output | DATA_W/8 | Lanes the current beat may use |
| strb_err | output | 1 | Strobe outside the window, one cycle after the beat |
| last_err | output | 1 | Last-beat marker misplaced, one cycle after the beat |

## Verification
The assertions assume that the transfer size never exceeds the bus width. They also assume that WRAP bursts start aligned and have 2, 4, 8 or 16 beats, since the window-width property depends on both. The stimulus sweeps only sizes 0 to 2 on a 4-lane bus, and it gives WRAP bursts only aligned starts with lengths 1 and 3. Address handshakes are issued only while idle, with one exception: a stray handshake is raised on purpose during the first beat of a burst, and the expected windows stay those of the burst already captured.

// File: rtl/wstrb_lane_monitor.sv
module wstrb_lane_monitor #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                aw_valid,
  input  logic                aw_ready,
  input  logic [ADDR_W-1:0]   aw_addr,
  input  logic [2:0]          aw_size,
  input  logic [7:0]          aw_len,
  input  logic [1:0]          aw_burst,
  input  logic                w_valid,
  input  logic                w_ready,
  input  logic [DATA_W/8-1:0] w_strb,
  input  logic                w_last,
  output logic [DATA_W/8-1:0] lane_mask,
  output logic                strb_err,
  output logic                last_err
);
  localparam int NB = DATA_W / 8;
  localparam int OW = $clog2(NB);
  localparam logic [1:0] FIXED = 2'd0;
  localparam logic [1:0] WRAP  = 2'd2;

  logic              active;
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] wrap_m;
  logic [2:0]        size_q;
  logic [1:0]        burst_q;
  logic [7:0]        left_q;

  wire              beat    = w_valid && w_ready && active;
  wire              capture = aw_valid && aw_ready && !active;
  wire [ADDR_W-1:0] step    = ADDR_W'(1) << size_q;
  wire [ADDR_W-1:0] aligned = cur_addr & ~(step - ADDR_W'(1));
  wire [ADDR_W-1:0] incr_nx = aligned + step;
  wire [ADDR_W-1:0] wrap_nx = (cur_addr & ~wrap_m) | (incr_nx & wrap_m);

  wire [OW:0] off   = {1'b0, cur_addr[OW-1:0]};
  wire [OW:0] width = (OW+1)'(1) << size_q;
  wire [OW:0] hi    = (off & ~(width - (OW+1)'(1))) + width;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign lane_mask[i] = active && ((OW+1)'(i) >= off) && ((OW+1)'(i) < hi);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      cur_addr <= '0;
      wrap_m   <= '0;
      size_q   <= '0;
      burst_q  <= '0;
      left_q   <= '0;
      strb_err <= 1'b0;
      last_err <= 1'b0;
    end else begin
      strb_err <= beat && |(w_strb & ~lane_mask);
      last_err <= beat && (w_last != (left_q == 8'd0));
      if (capture) begin
        active   <= 1'b1;
        cur_addr <= aw_addr;
        size_q   <= aw_size;
        burst_q  <= aw_burst;
        left_q   <= aw_len;
        wrap_m   <= ((ADDR_W'(aw_len) + ADDR_W'(1)) << aw_size) - ADDR_W'(1);
      end else if (beat) begin
        if (left_q == 8'd0) active <= 1'b0;
        left_q <= left_q - 8'd1;
        if (burst_q == WRAP)       cur_addr <= wrap_nx;
        else if (burst_q != FIXED) cur_addr <= incr_nx;
      end
    end
  end

  a_r7_strb_err_follows_beat: assert property (@(posedge clk) disable iff (!rst_n)
    strb_err |-> $past(w_valid && w_ready && active));

  a_r8_last_err_follows_beat: assert property (@(posedge clk) disable iff (!rst_n)
    last_err |-> $past(w_valid && w_ready && active));

  a_r2_window_width: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ($countones(lane_mask) >= 1 && $countones(lane_mask) <= int'(width)));

  a_r3_fixed_window_held: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && burst_q == FIXED) |-> $stable(lane_mask));

  a_r9_idle_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(beat) && $past(left_q) == 8'd0 && !$past(capture)) |-> lane_mask == '0);
endmodule

// File: tb/sim_wstrb_lane_monitor.sv
module sim_wstrb_lane_monitor;
  logic clk = 0, rst_n = 0;
  logic aw_valid = 0, aw_ready = 1;
  logic [15:0] aw_addr = '0;
  logic [2:0] aw_size = '0;
  logic [7:0] aw_len = '0;
  logic [1:0] aw_burst = '0;
  logic w_valid = 0, w_ready = 1, w_last = 0;
  logic [3:0] w_strb = '0;
  logic [3:0] lane_mask;
  logic strb_err, last_err;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  wstrb_lane_monitor #(.DATA_W(32), .ADDR_W(16)) u0 (
    .clk, .rst_n, .aw_valid, .aw_ready, .aw_addr, .aw_size, .aw_len, .aw_burst,
    .w_valid, .w_ready, .w_strb, .w_last, .lane_mask, .strb_err, .last_err);

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_mask(int a, int sz);
    int off = a % 4, b = 1 << sz, hi, m = 0;
    hi = (off / b) * b + b;
    for (int l = 0; l < 4; l++) if (l >= off && l < hi) m |= (1 << l);
    return m;
  endfunction

  function automatic int beat_addr(int bt, int st, int sz, int ln, int k);
    int b = 1 << sz, tot, base;
    if (bt == 0) return st;
    if (bt == 1) return (k == 0) ? st : (st / b) * b + k * b;
    tot = (ln + 1) * b;
    base = (st / tot) * tot;
    return base + ((st - base) + k * b) % tot;
  endfunction

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int idx = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check(lane_mask == 0 && !strb_err && !last_err, "R1 reset",
          {lane_mask, strb_err, last_err}, 0);
    for (int bt = 0; bt < 3; bt++)
      for (int sz = 0; sz < 3; sz++)
        for (int off = 0; off < 4; off++)
          for (int ln = 0; ln < 4; ln++) begin
            int st;
            if (bt == 2 && (ln == 0 || ln == 2 || off % (1 << sz) != 0)) continue;
            idx++;
            st = 16'h0100 + off;
            @(negedge clk);
            aw_valid = 1; aw_addr = 16'(st); aw_size = 3'(sz);
            aw_len = 8'(ln); aw_burst = 2'(bt);
            @(posedge clk); #1 aw_valid = 0;
            for (int k = 0; k <= ln; k++) begin
              int em, v, s, outside, wl, bad_s;
              string tag;
              em = exp_mask(beat_addr(bt, st, sz, ln, k), sz);
              v = idx + k;
              outside = ~em & 4'hF;
              bad_s = (v % 5 == 0) && outside != 0;
              s = bad_s ? (em | (outside & -outside)) : (em & ((v * 7) % 16));
              wl = (k == ln);
              if (idx % 7 == 3 && k == ln) wl = 0;
              if (idx % 7 == 5 && ln > 0 && k == 0) wl = 1;
              @(negedge clk);
              w_valid = 1; w_strb = 4'(s); w_last = wl[0];
              if (k == 0 && ln > 0) begin
                aw_valid = 1; aw_addr = 16'h0203; aw_size = 0; aw_burst = 1;
              end
              if (k == 0) tag = "R2";
              else if (bt == 0) tag = "R3 R10";
              else if (bt == 1) tag = "R4 R10";
              else tag = "R5 R10";
              check(lane_mask == 4'(em), tag, lane_mask, em);
              @(posedge clk); #1;
              aw_valid = 0;
              if (bad_s) check(strb_err == 1, "R7 outside", strb_err, 1);
              else check(strb_err == 0, "R6 subset", strb_err, 0);
              check(last_err == (wl != (k == ln)), "R8 last", last_err, int'(wl != (k == ln)));
            end
            @(negedge clk);
            w_valid = 0;
            check(lane_mask == 0, "R9 idle mask", lane_mask, 0);
            w_valid = 1; w_strb = 4'hF; w_last = 0;
            @(posedge clk); #1;
            w_valid = 0;
            check(!strb_err && !last_err, "R9 idle beat", {strb_err, last_err}, 0);
          end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule